// File: doc/BRIEF.md
# Microcoded Accumulator Processor

This block is a small accumulator processor whose every control signal is read from a control ROM of 20-bit microinstructions. A sequencer picks the next ROM address from a branch-condition field, a branch-type field and a target field. The datapath holds a program counter, an address register, a data register and an accumulator, next to a 2048-word by 16-bit main memory. The processor runs four memory-reference instructions: add, branch-if-negative, store and exchange. Each of them may use one level of indirect addressing.

Every instruction goes through the same steps. A fetch routine reads the word and dispatches on its opcode. The execute routine then calls a shared subroutine that forms the effective address when the indirect flag is set. After execution, control jumps back to fetch.

A loading port writes and reads main memory from outside. It preloads a program while the core is held in reset and inspects results afterwards. An opcode outside the four supported values stops the core, and `halt` rises.

Top module: `mcpu_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator, the program counter and `halt` clear to zero. The sequencer is placed at the fetch routine, at control address 64.
- R2: An instruction word carries its indirect flag in bit 15, its opcode in bits 14:11 and a direct address in bits 10:0.
- R3: Opcode 0000 adds M[EA] to the accumulator, modulo 2^16.
- R4: Opcode 0001 loads the program counter with EA only when accumulator bit 15 is 1. A zero or positive accumulator leaves the program counter at the following instruction.
- R5: Opcode 0010 writes the accumulator to M[EA].
- R6: Opcode 0011 places M[EA] in the accumulator and the old accumulator in M[EA].
- R7: With bit 15 set, the processor reads M[address] once and uses bits 10:0 of that word as EA. With bit 15 clear, EA is the address field.
- R8: A microinstruction is {F1[19:17], F2[16:14], F3[13:11], CD[10:9], BR[8:7], AD[6:0]}. The CD codes are 00 always, 01 instruction bit 15, 10 accumulator sign and 11 accumulator zero. The BR codes are 00 jump, 01 call, 10 return and 11 map. A map sends control to address opcode×4.
- R9: A taken call saves the control address plus one and jumps to AD. A return resumes at the saved address.
- R10: Mapping an opcode above 0011 sets `halt`. `halt` stays set until reset, and no register or memory word changes after that. The program counter then points past the stopping instruction.
- R11: Fetch takes 3 cycles. Execution takes 3 cycles for add, 2 for store, 4 for exchange, 2 for a branch not taken and 3 for a branch taken. Indirect addressing adds 2 cycles.
- R12: `ext_we` writes `ext_wdata` to M[`ext_addr`] at a clock edge, with priority over a store by the core. `ext_rdata` shows M[`ext_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_we | input | 1 | Loading-port write enable |
| ext_addr | input | 11 | Loading-port word address |
| ext_wdata | input | 16 | Loading-port write data |
| ext_rdata | output | 16 | Memory word at `ext_addr` |
| ac_out | output | 16 | Accumulator |
| pc_out | output | 11 | Program counter |
| halt | output | 1 | Core stopped on an unsupported opcode |

## Verification
Each program is released from reset on a falling edge. The bench then counts rising edges until `halt` is seen high at a falling edge. The expected count is the sum of the per-instruction costs in R11, for example 55 edges for the main program. That count confirms the microcode paths, the calls, the returns and the map target together. Accumulator, program counter and memory results are read at falling edges only after `halt` has risen. The bench reads them again ten cycles later to show that nothing moved. The loading port is sampled one time unit after its address settles, since its read path has no register.

// File: rtl/mcpu_pkg.sv
// Package: microinstruction layout, micro-operation codes and the
// computed control-ROM contents shared by the sequencer and datapath.
// Assumes a 7-bit control address and the fixed 20-bit word layout.
package mcpu_pkg;

    localparam int CA_W = 7;

    typedef struct packed {
        logic [2:0]      f1;
        logic [2:0]      f2;
        logic [2:0]      f3;
        logic [1:0]      cd;
        logic [1:0]      br;
        logic [CA_W-1:0] ad;
    } uword_t;

    // F1 group
    localparam logic [2:0] F1_NOP   = 3'd0;
    localparam logic [2:0] F1_ACADD = 3'd1;  // ac <= ac + dr
    localparam logic [2:0] F1_ACLDR = 3'd2;  // ac <= dr
    localparam logic [2:0] F1_ARPC  = 3'd3;  // ar <= pc
    localparam logic [2:0] F1_PCINC = 3'd4;  // pc <= pc + 1
    // F2 group
    localparam logic [2:0] F2_NOP   = 3'd0;
    localparam logic [2:0] F2_DRLM  = 3'd1;  // dr <= M[ar]
    localparam logic [2:0] F2_DRLAC = 3'd2;  // dr <= ac
    localparam logic [2:0] F2_ARLDR = 3'd3;  // ar <= dr address field
    localparam logic [2:0] F2_PCLAR = 3'd4;  // pc <= ar
    // F3 group
    localparam logic [2:0] F3_NOP   = 3'd0;
    localparam logic [2:0] F3_MWDR  = 3'd1;  // M[ar] <= dr
    localparam logic [2:0] F3_MWAC  = 3'd2;  // M[ar] <= ac

    localparam logic [1:0] CD_ALW  = 2'd0;
    localparam logic [1:0] CD_IND  = 2'd1;
    localparam logic [1:0] CD_SIGN = 2'd2;
    localparam logic [1:0] CD_ZERO = 2'd3;

    localparam logic [1:0] BR_JMP  = 2'd0;
    localparam logic [1:0] BR_CALL = 2'd1;
    localparam logic [1:0] BR_RET  = 2'd2;
    localparam logic [1:0] BR_MAP  = 2'd3;

    localparam logic [CA_W-1:0] A_FETCH = 7'd64;
    localparam logic [CA_W-1:0] A_INDR  = 7'd68;

    function automatic uword_t mk(input logic [2:0] f1, input logic [2:0] f2,
                                  input logic [2:0] f3, input logic [1:0] cd,
                                  input logic [1:0] br, input logic [CA_W-1:0] ad);
        uword_t w;
        w.f1 = f1; w.f2 = f2; w.f3 = f3; w.cd = cd; w.br = br; w.ad = ad;
        return w;
    endfunction

    // Microprogram: routines at opcode*4, fetch at 64, indirect subroutine at 68.
    function automatic uword_t rom_word(input logic [CA_W-1:0] a);
        case (a)
            // add
            7'd0:  return mk(F1_NOP,   F2_NOP,   F3_NOP,  CD_IND,  BR_CALL, A_INDR);
            7'd1:  return mk(F1_NOP,   F2_DRLM,  F3_NOP,  CD_ALW,  BR_JMP,  7'd2);
            7'd2:  return mk(F1_ACADD, F2_NOP,   F3_NOP,  CD_ALW,  BR_JMP,  A_FETCH);
            // branch if negative
            7'd4:  return mk(F1_NOP,   F2_NOP,   F3_NOP,  CD_SIGN, BR_JMP,  7'd6);
            7'd5:  return mk(F1_NOP,   F2_NOP,   F3_NOP,  CD_ALW,  BR_JMP,  A_FETCH);
            7'd6:  return mk(F1_NOP,   F2_NOP,   F3_NOP,  CD_IND,  BR_CALL, A_INDR);
            7'd7:  return mk(F1_NOP,   F2_PCLAR, F3_NOP,  CD_ALW,  BR_JMP,  A_FETCH);
            // store
            7'd8:  return mk(F1_NOP,   F2_NOP,   F3_NOP,  CD_IND,  BR_CALL, A_INDR);
            7'd9:  return mk(F1_NOP,   F2_NOP,   F3_MWAC, CD_ALW,  BR_JMP,  A_FETCH);
            // exchange
            7'd12: return mk(F1_NOP,   F2_NOP,   F3_NOP,  CD_IND,  BR_CALL, A_INDR);
            7'd13: return mk(F1_NOP,   F2_DRLM,  F3_NOP,  CD_ALW,  BR_JMP,  7'd14);
            7'd14: return mk(F1_ACLDR, F2_DRLAC, F3_NOP,  CD_ALW,  BR_JMP,  7'd15);
            7'd15: return mk(F1_NOP,   F2_NOP,   F3_MWDR, CD_ALW,  BR_JMP,  A_FETCH);
            // fetch
            7'd64: return mk(F1_ARPC,  F2_NOP,   F3_NOP,  CD_ALW,  BR_JMP,  7'd65);
            7'd65: return mk(F1_PCINC, F2_DRLM,  F3_NOP,  CD_ALW,  BR_JMP,  7'd66);
            7'd66: return mk(F1_NOP,   F2_ARLDR, F3_NOP,  CD_ALW,  BR_MAP,  7'd0);
            // indirect subroutine
            7'd68: return mk(F1_NOP,   F2_DRLM,  F3_NOP,  CD_ALW,  BR_JMP,  7'd69);
            7'd69: return mk(F1_NOP,   F2_ARLDR, F3_NOP,  CD_ALW,  BR_RET,  7'd0);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mcpu_urom.sv
// Control ROM: combinational lookup of the microinstruction at the
// current control address. Assumes contents come from mcpu_pkg::rom_word.
module mcpu_urom
    import mcpu_pkg::*;
#(
    parameter int CW = CA_W
) (
    input  logic [CW-1:0] car,
    output uword_t        uw
);
    localparam int DEPTH = 1 << CW;

    uword_t rom [DEPTH];

    // Fill each ROM location from the computed microprogram.
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = rom_word(CW'(i));
    end

    // Read the word addressed by the control address register.
    assign uw = rom[car];

endmodule

// File: rtl/mcpu_seq.sv
// Sequencer: holds the control address and the subroutine return
// register, evaluates the branch condition, and stops on a bad opcode.
// Assumes opcodes 0..MAX_OP are the only supported routines.
module mcpu_seq
    import mcpu_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int MAX_OP = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cd,
    input  logic [1:0]      br,
    input  logic [CA_W-1:0] ad,
    input  logic            ind_bit,
    input  logic            sign_bit,
    input  logic            zero_flag,
    input  logic [OP_W-1:0] opcode,
    output logic [CA_W-1:0] car,
    output logic            halt
);
    logic [CA_W-1:0] sbr;
    logic            cond;
    logic [CA_W-1:0] map_addr;

    // Select the status bit named by the condition field.
    always_comb begin
        case (cd)
            CD_ALW:  cond = 1'b1;
            CD_IND:  cond = ind_bit;
            CD_SIGN: cond = sign_bit;
            default: cond = zero_flag;
        endcase
    end

    // Map target: opcode placed two bits up, other bits zero.
    assign map_addr = CA_W'(opcode) << 2;

    // Advance the control address according to the branch field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car  <= A_FETCH;
            sbr  <= '0;
            halt <= 1'b0;
        end else if (!halt) begin
            case (br)
                BR_JMP:  car <= cond ? ad : car + 1'b1;
                BR_CALL: begin
                    if (cond) begin
                        car <= ad;
                        sbr <= car + 1'b1;
                    end else begin
                        car <= car + 1'b1;
                    end
                end
                BR_RET:  car <= sbr;
                default: begin
                    if (opcode > OP_W'(MAX_OP)) halt <= 1'b1;
                    else                        car  <= map_addr;
                end
            endcase
        end
    end

    a_r8_map_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && br == BR_MAP && opcode <= OP_W'(MAX_OP))
        |=> (car == (CA_W'($past(opcode)) << 2)));

    a_r9_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && br == BR_CALL && cond)
        |=> (sbr == $past(car) + 1'b1) && (car == $past(ad)));

    a_r9_ret_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && br == BR_RET) |=> (car == $past(sbr)));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (halt && $stable(car)));

endmodule

// File: rtl/mcpu_dp.sv
// Datapath: accumulator, data, address and program-counter registers
// plus main memory, driven by the three micro-operation fields.
// Assumes run is low once the core has stopped; the loading port
// writes memory regardless of run and wins over a core store.
module mcpu_dp
    import mcpu_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [2:0]        f1,
    input  logic [2:0]        f2,
    input  logic [2:0]        f3,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] ac,
    output logic [DATA_W-1:0] dr,
    output logic [ADDR_W-1:0] pc
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] ar;
    logic [DATA_W-1:0] mem_rd;

    // Combinational read at the address register and the loading port.
    assign mem_rd    = mem[ar];
    assign ext_rdata = mem[ext_addr];

    // Memory write: loading port first, then the core's store fields.
    always_ff @(posedge clk) begin
        if (ext_we)
            mem[ext_addr] <= ext_wdata;
        else if (run && f3 == F3_MWDR)
            mem[ar] <= dr;
        else if (run && f3 == F3_MWAC)
            mem[ar] <= ac;
    end

    // Register transfers selected by F1 and F2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac <= '0;
            dr <= '0;
            ar <= '0;
            pc <= '0;
        end else if (run) begin
            case (f1)
                F1_ACADD: ac <= ac + dr;
                F1_ACLDR: ac <= dr;
                F1_ARPC:  ar <= pc;
                F1_PCINC: pc <= pc + 1'b1;
                default:  ;
            endcase
            case (f2)
                F2_DRLM:  dr <= mem_rd;
                F2_DRLAC: dr <= ac;
                F2_ARLDR: ar <= dr[ADDR_W-1:0];
                F2_PCLAR: pc <= ar;
                default:  ;
            endcase
        end
    end

    a_r4_pc_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pc != $past(pc))
        |-> ((pc == $past(pc) + 1'b1) || (pc == $past(ar))));

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(rst_n) && !$past(run)) |-> ($stable(ac) && $stable(pc)));

endmodule

// File: rtl/mcpu_core.sv
// Top: microcoded accumulator processor. Joins the control ROM, the
// sequencer and the datapath. Assumes a 16-bit word with an 11-bit
// address field, a 4-bit opcode and the indirect flag on top.
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] ac_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic              halt
);
    localparam int OP_W = DATA_W - 1 - ADDR_W;

    logic [CA_W-1:0]   car;
    uword_t            uw;
    logic [DATA_W-1:0] ac;
    logic [DATA_W-1:0] dr;

    mcpu_urom #(.CW(CA_W)) i_urom (
        .car (car),
        .uw  (uw)
    );

    mcpu_seq #(.OP_W(OP_W), .MAX_OP(3)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cd        (uw.cd),
        .br        (uw.br),
        .ad        (uw.ad),
        .ind_bit   (dr[DATA_W-1]),
        .sign_bit  (ac[DATA_W-1]),
        .zero_flag (ac == '0),
        .opcode    (dr[DATA_W-2 -: OP_W]),
        .car       (car),
        .halt      (halt)
    );

    mcpu_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (!halt),
        .f1        (uw.f1),
        .f2        (uw.f2),
        .f3        (uw.f3),
        .ext_we    (ext_we),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_rdata (ext_rdata),
        .ac        (ac),
        .dr        (dr),
        .pc        (pc_out)
    );

    // Accumulator straight to the port.
    assign ac_out = ac;

endmodule

// File: tb/test_mcpu_core.sv
`timescale 1ns/1ps
module test_mcpu_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_we;
    logic [10:0] ext_addr;
    logic [15:0] ext_wdata;
    logic [15:0] ext_rdata;
    logic [15:0] ac_out;
    logic [10:0] pc_out;
    logic        halt;

    int nchk = 0;
    int nfail = 0;
    int cyc;

    always #2.5 clk = ~clk;

    mcpu_core i_mcpu_core (
        .clk(clk), .rst_n(rst_n), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ac_out(ac_out),
        .pc_out(pc_out), .halt(halt)
    );

    // Main program: {address, word}
    localparam logic [26:0] P1 [0:19] = '{
        {11'd0,   16'h0064}, {11'd1,   16'h8065}, {11'd2,   16'h1067},
        {11'd3,   16'h1868}, {11'd4,   16'h0814}, {11'd5,   16'h0069},
        {11'd6,   16'h886A}, {11'd7,   16'h2000}, {11'd10,  16'h906B},
        {11'd11,  16'h7800}, {11'd100, 16'h0005}, {11'd101, 16'h0066},
        {11'd102, 16'hFFF0}, {11'd103, 16'h0000}, {11'd104, 16'h0007},
        {11'd105, 16'hFFF0}, {11'd106, 16'h000A}, {11'd107, 16'h006C},
        {11'd108, 16'h0000}, {11'd20,  16'h0000}};

    // Expected memory after P1: {tag, address, word}
    localparam logic [42:0] E1 [0:6] = '{
        {"R5", 11'd103, 16'hFFF5},   // direct store of the sum
        {"R6", 11'd104, 16'hFFF5},   // exchange put old AC in memory
        {"R7", 11'd108, 16'hFFF7},   // store through pointer at 107
        {"R7", 11'd102, 16'hFFF0},   // indirect operand left intact
        {"R3", 11'd100, 16'h0005},   // add does not write memory
        {"R4", 11'd20,  16'h0000},   // untaken branch target untouched
        {"R10", 11'd7,  16'h2000}};  // skipped word untouched

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        ext_we = 1'b1; ext_addr = a; ext_wdata = d;
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic peek(input logic [10:0] a, output logic [15:0] d);
        ext_addr = a;
        #1 d = ext_rdata;
    endtask

    task automatic run_to_halt();
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!halt && cyc < 2000);
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog actual=hung expected=halt");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] ac_hold;
        rst_n = 1'b0; ext_we = 1'b0; ext_addr = '0; ext_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ac reset", ac_out, 0);
        chk("R1 pc reset", pc_out, 0);
        chk("R1 halt reset", halt, 0);

        // Program 1: walk the vector table to load, run, then check.
        for (int i = 0; i < 20; i++) load(P1[i][26:16], P1[i][15:0]);
        peek(11'd100, rd);
        chk("R12 loading port readback", rd, 16'h0005);
        run_to_halt();
        chk("R11 R8 R9 R2 program 1 cycles", cyc, 55);
        chk("R10 halt set", halt, 1);
        chk("R3 R6 final accumulator", ac_out, 16'hFFF7);
        chk("R4 R10 final pc", pc_out, 12);
        for (int i = 0; i < 7; i++) begin
            peek(E1[i][26:16], rd);
            chk($sformatf("%s memory word %0d", E1[i][42:27], E1[i][26:16]), rd, E1[i][15:0]);
        end
        ac_hold = ac_out;
        repeat (10) @(negedge clk);
        chk("R10 ac frozen", ac_out, ac_hold);
        chk("R10 pc frozen", pc_out, 12);
        peek(11'd108, rd);
        chk("R10 memory frozen", rd, 16'hFFF7);

        // Program 2: branch with zero accumulator is not taken.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 halt cleared by reset", halt, 0);
        chk("R1 ac cleared by reset", ac_out, 0);
        load(11'd0, 16'h0805);
        load(11'd1, 16'h2800);
        run_to_halt();
        chk("R11 program 2 cycles", cyc, 8);
        chk("R4 zero is not negative", pc_out, 2);

        // Program 3: add wrap to negative, taken branch, indirect exchange.
        @(negedge clk);
        rst_n = 1'b0;
        load(11'd0, 16'h0032);
        load(11'd1, 16'h0033);
        load(11'd2, 16'h0806);
        load(11'd6, 16'h9834);
        load(11'd7, 16'h7800);
        load(11'd50, 16'h7FFF);
        load(11'd51, 16'h0001);
        load(11'd52, 16'h0035);
        load(11'd53, 16'h1234);
        run_to_halt();
        chk("R11 R9 program 3 cycles", cyc, 30);
        chk("R6 R7 exchanged accumulator", ac_out, 16'h1234);
        peek(11'd53, rd);
        chk("R3 R6 wrapped sum swapped out", rd, 16'h8000);
        chk("R4 taken branch pc", pc_out, 8);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule